// File: doc/BRIEF.md
# Card Command Transaction Sequencer

This block runs a single command transaction on the command line of a memory card. The caller supplies a 14-bit configuration word and a 32-bit argument, then pulses `start`. The sequencer asks a serializer to transmit the command and, depending on the configuration, waits for a short or long response. It can check the response CRC result and the echoed command index, and it can wait while the card signals busy. On success it reports completion and can then launch a read or write data phase. Bit-level shifting and CRC7 generation belong to the serializer. The serializer talks to the sequencer through a request/sent handshake and a receive-done pulse, which carries the response bits, the received index and a CRC-ok flag.

A watchdog counts card-clock ticks while the transaction waits on the serializer or the card. If the programmed limit is reached, the transaction is aborted with a timeout event. Only one transaction runs at a time. A synchronous software reset abandons any transaction in progress.

Top module: `cmd_txn_seq`

## Requirements
- R1: After `rst`, `active`, `ser_req`, every event output and both data-start outputs are 0, and `resp_words` is all zero.
- R2: A `start` pulse sampled while idle latches `cfg` and `arg`. In the next cycle `ser_req` is 1 and `ser_index` equals `cfg[13:8]`. `ser_arg` equals the argument. `ser_expect_resp` is 1 when `cfg[1:0]` is nonzero, and `ser_long_resp` equals `cfg[1]` (1 = short 48-bit, 2 or 3 = long 136-bit).
- R3: When `cfg[1:0]`=0, the response inputs and both checks are ignored. If busy waiting is off, `evt_done` is 1 in the cycle right after the cycle in which `ser_sent` is sampled, and `resp_words` keeps its value.
- R4: For a short response, a successful transaction loads `rx_bits[31:0]` into `resp_words[31:0]` and clears `resp_words[127:32]`. The new value is visible in the cycle in which `evt_done` is 1, two cycles after `rx_done` is sampled.
- R5: For a long response, a successful transaction loads all 120 bits. Word k is `resp_words[32k+31:32k]`, and word 3 holds `rx_bits[119:96]` with its top 8 bits zero.
- R6: With `cfg[3]`=1 and `rx_crc_ok`=0, the cycle after the check has `evt_crc`=1 and `evt_err`=1, with `evt_done`=0 and `active`=0. `resp_words` is unchanged and no data phase starts. With `cfg[3]`=0, `rx_crc_ok` has no effect.
- R7: With `cfg[4]`=1 and `rx_index` different from `cfg[13:8]`, the sequencer behaves as in R6 except that `evt_idx` is raised in place of `evt_crc`. With `cfg[4]`=0, the index is not compared.
- R8: With `cfg[2]`=1, completion waits while `card_busy` is 1. `evt_done` rises in the cycle after the first edge at which `card_busy` is sampled 0. With `cfg[2]`=0, `card_busy` is ignored.
- R9: `cfg[6:5]`=1 pulses `data_rd_start`, and `cfg[6:5]`=2 pulses `data_wr_start`, for one cycle in the cycle after `evt_done`. The values 0 and 3 start nothing.
- R10: The watchdog counts `card_tick` cycles while the sequencer waits on the serializer or on busy. When the count reaches a nonzero `tmo_limit`, `evt_tmo` and `evt_err` pulse and `active` returns to 0. With a tick every cycle, this happens `tmo_limit`+1 cycles after `ser_req` rises. With no ticks it never happens, and a limit of 0 disables it.
- R11: A `start` pulse while `active` is 1 is ignored. The latched index and argument do not change, and no second transaction follows.
- R12: A `sw_rst` pulse returns the sequencer to idle in the next cycle and clears the watchdog count, so a new transaction gets the full timeout window.
- R13: Every event output is a single-cycle pulse. `evt_err` is 1 exactly when one of `evt_tmo`, `evt_crc` or `evt_idx` is 1, and it is never 1 together with `evt_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Synchronous abort to idle |
| start | input | 1 | Begin a transaction (pulse) |
| cfg | input | 14 | Command configuration word |
| arg | input | 32 | Command argument |
| tmo_limit | input | TMO_W | Watchdog limit in card ticks, 0 disables |
| card_tick | input | 1 | One pulse per card-clock cycle |
| ser_req | output | 1 | Request to the serializer to send the command |
| ser_index | output | 6 | Command index to send |
| ser_arg | output | 32 | Argument to send |
| ser_expect_resp | output | 1 | A response is expected |
| ser_long_resp | output | 1 | Expected response is the long form |
| ser_sent | input | 1 | Serializer finished sending (pulse) |
| rx_done | input | 1 | Response received (pulse) |
| rx_bits | input | RESP_W | Response payload |
| rx_index | input | 6 | Index carried by the response |
| rx_crc_ok | input | 1 | Response CRC matched |
| card_busy | input | 1 | Card busy indication |
| data_rd_start | output | 1 | Launch read data phase (pulse) |
| data_wr_start | output | 1 | Launch write data phase (pulse) |
| active | output | 1 | A transaction is in progress |
| evt_done | output | 1 | Successful completion event |
| evt_err | output | 1 | Combined error event |
| evt_tmo | output | 1 | Watchdog timeout event |
| evt_crc | output | 1 | Response CRC error event |
| evt_idx | output | 1 | Response index error event |
| resp_words | output | 4*WORD_W | Stored response, four words |

## Verification
The main flow is driven with each response mode: none, short and long. The three modes are told apart by which words of the stored response change and by the completion cycle. CRC and index failures are injected both with their check enabled and with it disabled, which separates a real check from a missing one or from a check wired to the wrong enable. Busy is held for several cycles and then released, and the same is done with busy waiting disabled. The watchdog is run with a tick every cycle, with no ticks and with a zero limit, and its firing cycle is measured exactly, which exposes an off-by-one limit compare or a count that is not cleared by software reset.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int CFG_W = 14;
  localparam int IDX_W = 6;
  localparam int ARG_W = 32;

  // Field layout of the configuration word (MSB first).
  typedef struct packed {
    logic [IDX_W-1:0] index;    // [13:8]
    logic             rsvd;     // [7]
    logic [1:0]       data_dir; // [6:5]
    logic             idx_chk;  // [4]
    logic             crc_chk;  // [3]
    logic             busy_chk; // [2]
    logic [1:0]       resp_sel; // [1:0]
  } cmd_cfg_t;

  localparam logic [1:0] DIR_READ  = 2'd1;
  localparam logic [1:0] DIR_WRITE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT_RESP, ST_CHECK, ST_WAIT_BUSY, ST_START_DATA, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/cmd_seq_watchdog.sv
module cmd_seq_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/cmd_seq_resp_check.sv
module cmd_seq_resp_check #(
  parameter int IDX_W = 6
) (
  input  logic             crc_en,
  input  logic             idx_en,
  input  logic             crc_ok,
  input  logic [IDX_W-1:0] exp_idx,
  input  logic [IDX_W-1:0] got_idx,
  output logic             crc_fail,
  output logic             idx_fail
);
  always_comb begin
    crc_fail = crc_en && !crc_ok;
    idx_fail = idx_en && (got_idx != exp_idx);
  end
endmodule

// File: rtl/cmd_seq_resp_regs.sv
module cmd_seq_resp_regs #(
  parameter int RESP_W  = 120,
  parameter int WORD_W  = 32,
  localparam int N_WORDS = (RESP_W + WORD_W - 1) / WORD_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic                      long_resp,
  input  logic [RESP_W-1:0]         bits,
  output logic [N_WORDS*WORD_W-1:0] words
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam int LO   = w * WORD_W;
    localparam int HI   = (LO + WORD_W > RESP_W) ? RESP_W - 1 : LO + WORD_W - 1;
    localparam int SPAN = HI - LO + 1;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] word_q;

    // Short responses fill only the lowest word; the rest is cleared.
    always_comb begin
      src = '0;
      if (w == 0 || long_resp) src[SPAN-1:0] = bits[HI:LO];
    end

    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (capture) word_q <= src;
    end

    assign words[LO +: WORD_W] = word_q;
  end
endmodule

// File: rtl/cmd_txn_seq.sv
module cmd_txn_seq
  import cmd_seq_pkg::*;
#(
  parameter int TMO_W  = 16,
  parameter int RESP_W = 120,
  parameter int WORD_W = 32,
  localparam int N_WORDS = (RESP_W + WORD_W - 1) / WORD_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sw_rst,
  input  logic                      start,
  input  logic [CFG_W-1:0]          cfg,
  input  logic [ARG_W-1:0]          arg,
  input  logic [TMO_W-1:0]          tmo_limit,
  input  logic                      card_tick,
  output logic                      ser_req,
  output logic [IDX_W-1:0]          ser_index,
  output logic [ARG_W-1:0]          ser_arg,
  output logic                      ser_expect_resp,
  output logic                      ser_long_resp,
  input  logic                      ser_sent,
  input  logic                      rx_done,
  input  logic [RESP_W-1:0]         rx_bits,
  input  logic [IDX_W-1:0]          rx_index,
  input  logic                      rx_crc_ok,
  input  logic                      card_busy,
  output logic                      data_rd_start,
  output logic                      data_wr_start,
  output logic                      active,
  output logic                      evt_done,
  output logic                      evt_err,
  output logic                      evt_tmo,
  output logic                      evt_crc,
  output logic                      evt_idx,
  output logic [N_WORDS*WORD_W-1:0] resp_words
);
  seq_state_e        state_q, state_d;
  cmd_cfg_t          cfg_q;
  logic [ARG_W-1:0]  arg_q;
  logic [RESP_W-1:0] rx_bits_q;
  logic [IDX_W-1:0]  rx_idx_q;
  logic              rx_crc_q;
  logic              expired, crc_fail, idx_fail;
  logic              ev_tmo, ev_crc, ev_idx, commit;
  logic              wd_run, wd_clear;
  seq_state_e        after_cmd;

  assign wd_run   = (state_q == ST_SEND) || (state_q == ST_WAIT_RESP) ||
                    (state_q == ST_WAIT_BUSY);
  assign wd_clear = sw_rst || (state_q == ST_IDLE);

  cmd_seq_watchdog #(.CNT_W(TMO_W)) i_wdog (
    .clk(clk), .rst(rst), .clear(wd_clear), .run(wd_run), .tick(card_tick),
    .limit(tmo_limit), .expired(expired)
  );

  cmd_seq_resp_check #(.IDX_W(IDX_W)) i_check (
    .crc_en(cfg_q.crc_chk), .idx_en(cfg_q.idx_chk), .crc_ok(rx_crc_q),
    .exp_idx(cfg_q.index), .got_idx(rx_idx_q),
    .crc_fail(crc_fail), .idx_fail(idx_fail)
  );

  cmd_seq_resp_regs #(.RESP_W(RESP_W), .WORD_W(WORD_W)) i_resp (
    .clk(clk), .rst(rst), .capture(commit), .long_resp(cfg_q.resp_sel[1]),
    .bits(rx_bits_q), .words(resp_words)
  );

  assign after_cmd = cfg_q.busy_chk ? ST_WAIT_BUSY : ST_DONE;

  always_comb begin
    state_d = state_q;
    ev_tmo  = 1'b0;
    ev_crc  = 1'b0;
    ev_idx  = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_SEND;
      ST_SEND: begin
        if (expired) begin
          ev_tmo = 1'b1; state_d = ST_IDLE;
        end else if (ser_sent) begin
          state_d = (cfg_q.resp_sel == 2'd0) ? after_cmd : ST_WAIT_RESP;
        end
      end
      ST_WAIT_RESP: begin
        if (expired) begin
          ev_tmo = 1'b1; state_d = ST_IDLE;
        end else if (rx_done) begin
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (crc_fail || idx_fail) begin
          ev_crc = crc_fail; ev_idx = idx_fail; state_d = ST_IDLE;
        end else begin
          commit = 1'b1; state_d = after_cmd;
        end
      end
      ST_WAIT_BUSY: begin
        if (expired) begin
          ev_tmo = 1'b1; state_d = ST_IDLE;
        end else if (!card_busy) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = (cfg_q.data_dir == DIR_READ || cfg_q.data_dir == DIR_WRITE)
                         ? ST_START_DATA : ST_IDLE;
      ST_START_DATA: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      state_q       <= ST_IDLE;
      ser_req       <= 1'b0;
      active        <= 1'b0;
      evt_done      <= 1'b0;
      evt_err       <= 1'b0;
      evt_tmo       <= 1'b0;
      evt_crc       <= 1'b0;
      evt_idx       <= 1'b0;
      data_rd_start <= 1'b0;
      data_wr_start <= 1'b0;
    end else begin
      state_q       <= state_d;
      ser_req       <= (state_d == ST_SEND);
      active        <= (state_d != ST_IDLE);
      evt_done      <= (state_d == ST_DONE);
      evt_err       <= ev_tmo || ev_crc || ev_idx;
      evt_tmo       <= ev_tmo;
      evt_crc       <= ev_crc;
      evt_idx       <= ev_idx;
      data_rd_start <= (state_d == ST_START_DATA) && (cfg_q.data_dir == DIR_READ);
      data_wr_start <= (state_d == ST_START_DATA) && (cfg_q.data_dir == DIR_WRITE);
    end
  end

  // Latched command setup and received response; no reset needed for data.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      arg_q <= '0;
    end else if (state_q == ST_IDLE && start && !sw_rst) begin
      cfg_q <= cmd_cfg_t'(cfg);
      arg_q <= arg;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_WAIT_RESP && state_d == ST_CHECK) begin
      rx_bits_q <= rx_bits;
      rx_idx_q  <= rx_index;
      rx_crc_q  <= rx_crc_ok;
    end
  end

  assign ser_index       = cfg_q.index;
  assign ser_arg         = arg_q;
  assign ser_expect_resp = (cfg_q.resp_sel != 2'd0);
  assign ser_long_resp   = cfg_q.resp_sel[1];
endmodule

// File: rtl/cmd_txn_seq_sva.sv
module cmd_txn_seq_sva (
  input logic clk,
  input logic rst,
  input logic sw_rst,
  input logic ser_req,
  input logic active,
  input logic data_rd_start,
  input logic data_wr_start,
  input logic evt_done,
  input logic evt_err,
  input logic evt_tmo,
  input logic evt_crc,
  input logic evt_idx
);
  a_r11_req_only_when_active: assert property (@(posedge clk) disable iff (rst)
    ser_req |-> active);

  a_r13_err_has_cause: assert property (@(posedge clk) disable iff (rst)
    evt_err |-> (evt_tmo || evt_crc || evt_idx));

  a_r13_cause_sets_err: assert property (@(posedge clk) disable iff (rst)
    (evt_tmo || evt_crc || evt_idx) |-> evt_err);

  a_r13_done_excludes_err: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_done, evt_err}));

  a_r13_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    evt_done |=> !evt_done);

  a_r9_data_after_done: assert property (@(posedge clk) disable iff (rst)
    (data_rd_start || data_wr_start) |-> $past(evt_done));

  a_r9_one_direction: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_rd_start, data_wr_start}));

  a_r6_fail_ends_txn: assert property (@(posedge clk) disable iff (rst)
    (evt_crc || evt_idx) |-> !active);

  a_r10_timeout_ends_txn: assert property (@(posedge clk) disable iff (rst)
    evt_tmo |-> !active);

  a_r12_swrst_to_idle: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!active && !ser_req));
endmodule

bind cmd_txn_seq cmd_txn_seq_sva i_sva (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .ser_req(ser_req), .active(active),
  .data_rd_start(data_rd_start), .data_wr_start(data_wr_start),
  .evt_done(evt_done), .evt_err(evt_err), .evt_tmo(evt_tmo),
  .evt_crc(evt_crc), .evt_idx(evt_idx)
);

// File: tb/test_cmd_txn_seq.sv
`timescale 1ns/1ps
module test_cmd_txn_seq;
  localparam int TMO_W = 16;
  localparam int RESP_W = 120;
  localparam int WORD_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1, sw_rst = 1'b0, start = 1'b0;
  logic [13:0] cfg = '0;
  logic [31:0] arg = '0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic card_tick = 1'b1;
  logic ser_req, ser_expect_resp, ser_long_resp;
  logic [5:0] ser_index;
  logic [31:0] ser_arg;
  logic ser_sent = 1'b0, rx_done = 1'b0, rx_crc_ok = 1'b1, card_busy = 1'b0;
  logic [RESP_W-1:0] rx_bits = '0;
  logic [5:0] rx_index = '0;
  logic data_rd_start, data_wr_start, active;
  logic evt_done, evt_err, evt_tmo, evt_crc, evt_idx;
  logic [127:0] resp_words;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [119:0] PAT_A = 120'h11223344_55667788_99AABBCC_DDEEFF;
  localparam logic [119:0] PAT_B = 120'hA1B2C3_D4E5F607_18293A4B_5C6D7E8F;

  always #10 clk = ~clk;

  cmd_txn_seq #(.TMO_W(TMO_W), .RESP_W(RESP_W), .WORD_W(WORD_W)) i_cmd_txn_seq (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .start(start), .cfg(cfg), .arg(arg),
    .tmo_limit(tmo_limit), .card_tick(card_tick), .ser_req(ser_req),
    .ser_index(ser_index), .ser_arg(ser_arg), .ser_expect_resp(ser_expect_resp),
    .ser_long_resp(ser_long_resp), .ser_sent(ser_sent), .rx_done(rx_done),
    .rx_bits(rx_bits), .rx_index(rx_index), .rx_crc_ok(rx_crc_ok),
    .card_busy(card_busy), .data_rd_start(data_rd_start),
    .data_wr_start(data_wr_start), .active(active), .evt_done(evt_done),
    .evt_err(evt_err), .evt_tmo(evt_tmo), .evt_crc(evt_crc), .evt_idx(evt_idx),
    .resp_words(resp_words)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [13:0] mk(input logic [5:0] idx, input logic [1:0] dir,
                                     input logic ichk, input logic cchk,
                                     input logic bchk, input logic [1:0] rsel);
    return {idx, 1'b0, dir, ichk, cchk, bchk, rsel};
  endfunction

  task automatic launch(input logic [13:0] c, input logic [31:0] a);
    cfg = c; arg = a; start = 1'b1;
    cyc();
    start = 1'b0;
  endtask

  task automatic send_cmd();
    ser_sent = 1'b1;
    cyc();
    ser_sent = 1'b0;
  endtask

  task automatic give_resp(input logic [119:0] b, input logic [5:0] idx, input logic ok);
    rx_bits = b; rx_index = idx; rx_crc_ok = ok; rx_done = 1'b1;
    cyc();
    rx_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "active", active, 0);
    chk("R1", "ser_req", ser_req, 0);
    chk("R1", "events", {evt_done, evt_err, evt_tmo, evt_crc, evt_idx}, 0);
    chk("R1", "data starts", {data_rd_start, data_wr_start}, 0);
    chk("R1", "resp_words", resp_words, 0);
  endtask

  task automatic t_no_resp();
    launch(mk(6'd5, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0), 32'h1234_5678);
    chk("R2", "ser_req", ser_req, 1);
    chk("R2", "ser_index", ser_index, 6'd5);
    chk("R2", "ser_arg", ser_arg, 32'h1234_5678);
    chk("R2", "ser_expect_resp", ser_expect_resp, 0);
    rx_crc_ok = 1'b0; rx_index = 6'd63;
    send_cmd();
    chk("R3", "evt_done", evt_done, 1);
    chk("R3", "evt_err", evt_err, 0);
    chk("R3", "resp_words kept", resp_words, 0);
    cyc();
    chk("R3", "idle after done", active, 0);
    rx_crc_ok = 1'b1;
  endtask

  task automatic t_short();
    launch(mk(6'd17, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1), 32'hCAFE_0001);
    chk("R2", "expect short", {ser_expect_resp, ser_long_resp}, 2'b10);
    send_cmd();
    give_resp(PAT_A, 6'd17, 1'b1);
    chk("R4", "no early done", evt_done, 0);
    cyc();
    chk("R4", "evt_done", evt_done, 1);
    chk("R4", "short words", resp_words, {96'h0, PAT_A[31:0]});
    cyc();
  endtask

  task automatic t_long();
    launch(mk(6'd2, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2), 32'h0);
    chk("R2", "expect long", {ser_expect_resp, ser_long_resp}, 2'b11);
    send_cmd();
    give_resp(PAT_B, 6'd0, 1'b1);
    cyc();
    chk("R5", "evt_done", evt_done, 1);
    chk("R5", "long words", resp_words, {8'h00, PAT_B});
    cyc();
  endtask

  task automatic t_crc();
    launch(mk(6'd3, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1), 32'h0);
    send_cmd();
    give_resp(PAT_A, 6'd3, 1'b0);
    cyc();
    chk("R6", "crc/err/done/active", {evt_crc, evt_err, evt_done, active}, 4'b1100);
    chk("R6", "evt_idx", evt_idx, 0);
    chk("R6", "words unchanged", resp_words, {8'h00, PAT_B});
    cyc();
    chk("R6", "no data start", {data_rd_start, data_wr_start}, 0);
    launch(mk(6'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1), 32'h0);
    send_cmd();
    give_resp(PAT_A, 6'd3, 1'b0);
    cyc();
    chk("R6", "crc ignored when off", {evt_done, evt_err}, 2'b10);
    chk("R6", "words loaded", resp_words, {96'h0, PAT_A[31:0]});
    cyc();
  endtask

  task automatic t_idx();
    launch(mk(6'd9, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1), 32'h0);
    send_cmd();
    give_resp(PAT_B, 6'd10, 1'b1);
    cyc();
    chk("R7", "idx/crc/err/done", {evt_idx, evt_crc, evt_err, evt_done}, 4'b1010);
    chk("R7", "idle", active, 0);
    chk("R7", "words unchanged", resp_words, {96'h0, PAT_A[31:0]});
    cyc();
    launch(mk(6'd9, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1), 32'h0);
    send_cmd();
    give_resp(PAT_B, 6'd10, 1'b1);
    cyc();
    chk("R7", "idx ignored when off", {evt_done, evt_err}, 2'b10);
    cyc();
  endtask

  task automatic t_busy();
    card_busy = 1'b1;
    launch(mk(6'd4, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0), 32'h0);
    send_cmd();
    for (int i = 0; i < 5; i++) begin
      chk("R8", "held while busy", {evt_done, active}, 2'b01);
      cyc();
    end
    card_busy = 1'b0;
    cyc();
    chk("R8", "done after release", evt_done, 1);
    cyc();
    card_busy = 1'b1;
    launch(mk(6'd4, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0), 32'h0);
    send_cmd();
    chk("R8", "busy ignored when off", evt_done, 1);
    cyc();
    card_busy = 1'b0;
  endtask

  task automatic t_data(input logic [1:0] dir, input logic exp_rd, input logic exp_wr);
    launch(mk(6'd1, dir, 1'b0, 1'b0, 1'b0, 2'd0), 32'h0);
    send_cmd();
    chk("R9", "done, no start yet", {evt_done, data_rd_start, data_wr_start}, 3'b100);
    cyc();
    chk("R9", "data start", {data_rd_start, data_wr_start}, {exp_rd, exp_wr});
    cyc();
    chk("R9", "start is a pulse", {data_rd_start, data_wr_start, active}, 3'b000);
  endtask

  task automatic t_timeout();
    int hit = 0;
    tmo_limit = 16'd3;
    launch(mk(6'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1), 32'h0);
    for (int i = 1; i <= 8; i++) begin
      cyc();
      if (evt_tmo && hit == 0) begin
        hit = i;
        chk("R10", "err with timeout", evt_err, 1);
        chk("R10", "idle on timeout", active, 0);
      end
    end
    chk("R10", "timeout cycle", hit, 4);
    card_tick = 1'b0;
    hit = 0;
    launch(mk(6'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0), 32'h0);
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (evt_tmo) hit = 1;
    end
    chk("R10", "no ticks no timeout", {hit[0], active}, 2'b01);
    card_tick = 1'b1;
    tmo_limit = 16'd0;
    send_cmd();
    chk("R10", "completes after stall", evt_done, 1);
    cyc();
    hit = 0;
    launch(mk(6'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0), 32'h0);
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (evt_tmo) hit = 1;
    end
    chk("R10", "limit 0 disables", {hit[0], active}, 2'b01);
    send_cmd();
    cyc();
  endtask

  task automatic t_ignore_start();
    launch(mk(6'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0), 32'h0000_AAAA);
    cyc();
    cfg = mk(6'd9, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0); arg = 32'h0000_BBBB; start = 1'b1;
    cyc();
    start = 1'b0;
    chk("R11", "index kept", ser_index, 6'd7);
    chk("R11", "arg kept", ser_arg, 32'h0000_AAAA);
    send_cmd();
    chk("R11", "first completes", evt_done, 1);
    cyc();
    cyc();
    chk("R11", "no second txn", {active, ser_req}, 2'b00);
  endtask

  task automatic t_swrst();
    int hit = 0;
    tmo_limit = 16'd6;
    launch(mk(6'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1), 32'h0);
    repeat (4) cyc();
    sw_rst = 1'b1;
    cyc();
    sw_rst = 1'b0;
    chk("R12", "idle after sw_rst", {active, ser_req, evt_tmo}, 3'b000);
    launch(mk(6'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1), 32'h0);
    for (int i = 1; i <= 10; i++) begin
      cyc();
      if (evt_tmo && hit == 0) hit = i;
    end
    chk("R12", "full window after sw_rst", hit, 7);
    tmo_limit = 16'd0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_no_resp();
    t_short();
    t_long();
    t_crc();
    t_idx();
    t_busy();
    t_data(2'd1, 1'b1, 1'b0);
    t_data(2'd2, 1'b0, 1'b1);
    t_data(2'd3, 1'b0, 1'b0);
    t_data(2'd0, 1'b0, 1'b0);
    t_timeout();
    t_ignore_start();
    t_swrst();
    chk("R13", "events quiet at end", {evt_done, evt_err, evt_tmo, evt_crc, evt_idx}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule